// File: doc/BRIEF.md
# Sign-Referenced Phase Alignment Unit

This unit nudges one digital square-wave oscillator toward the level its coupling asks for. Every clock it turns a held, signed coupling sum into a reference square level. A positive sum asks for a high level and a negative sum asks for a low level. A sum of zero leaves the reference equal to whatever the oscillator currently outputs.

The unit times how many clock steps separate a rising edge of the oscillator output from the next rising edge of the reference. That count, modulo the number of phase steps, becomes the pending correction.

When the phase-update strobe arrives, the pending correction is added, with wrap-around, to a phase register. The oscillator uses that register as its tap select. A correction is applied once and then cleared. The phase register can also be loaded directly with a start value, and a load wins over an update in the same cycle.

Top module: `phase_align_unit`

## Requirements
- R1: A positive `sum_i` drives the reference high and a negative `sum_i` drives it low; a reference rising edge is therefore seen in the cycle `sum_i` turns from negative to positive.
- R2: While `sum_i` is zero the reference equals `osc_i`, so a measurement started in that state yields a correction of 0 and replaces any pending correction.
- R3: A rising edge of `osc_i` starts a timer. The next reference rising edge d clock cycles later (1 ≤ d ≤ 2^PHASE_W−1) makes the pending correction d. A reference rising edge in the same cycle as the oscillator rising edge yields 0.
- R4: If no reference rising edge arrives within 2^PHASE_W−1 cycles of the oscillator rising edge, the correction is 0, and a later reference edge has no effect.
- R5: In the cycle after `update_i` is high (without `load_i`), `phase_o` equals the previous phase plus the pending correction, modulo 2^PHASE_W.
- R6: An applied correction is cleared, so a further update with no new measurement leaves `phase_o` unchanged.
- R7: `load_i` writes `load_phase_i` into the phase register on the next edge. It overrides an update in the same cycle, and that update neither applies nor clears the pending correction.
- R8: Reset gives phase 0, pending correction 0 and no measurement in progress.
- R9: Without `update_i` or `load_i`, `phase_o` holds its value whatever `sum_i` and `osc_i` do.
- R10: An oscillator rising edge during a running measurement restarts the timer from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick is one phase step |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sum_i | input | SUM_W | Held signed coupling sum (two's complement) |
| osc_i | input | 1 | Present oscillator amplitude, 1 = high |
| update_i | input | 1 | Apply pending correction to the phase |
| load_i | input | 1 | Load a start phase |
| load_phase_i | input | PHASE_W | Start phase value |
| phase_o | output | PHASE_W | Phase register |

## Verification
The hardest situation to reach is a correction at the edges of the window. A reference edge exactly 2^PHASE_W−1 steps after the oscillator edge must still count. An edge one step later must be lost to the timeout. An oscillator edge landing mid-measurement must restart the timer.

The stimulus gets there by steering `sum_i` cycle by cycle, so that the reference rises at a chosen offset from a hand-placed oscillator edge. It then holds both inputs quiet until the strobe, and reads the result only through the phase increment that follows.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic {
    T_IDLE = 1'b0,
    T_RUN  = 1'b1
  } timer_state_e;
endpackage

// File: rtl/pau_ref_gen.sv
module pau_ref_gen #(
  parameter int SUM_W = 10
) (
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic                    osc_i,
  output logic                    ref_o
);
  logic sum_zero;

  always_comb begin
    sum_zero = (sum_i == '0);
    // zero sum: follow the oscillator so no correction is forced
    ref_o    = sum_zero ? osc_i : ~sum_i[SUM_W-1];
  end
endmodule

// File: rtl/pau_edge_timer.sv
module pau_edge_timer
  import pau_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_i,
  input  logic               ref_i,
  output logic               res_vld_o,
  output logic [PHASE_W-1:0] res_o
);
  localparam logic [PHASE_W-1:0] CNT_MAX = {PHASE_W{1'b1}};

  timer_state_e       state_q;
  logic [PHASE_W-1:0] cnt_q;
  logic               osc_q, ref_q;
  logic               osc_rise, ref_rise, timeout, hit;

  always_comb begin
    osc_rise  = osc_i & ~osc_q;
    ref_rise  = ref_i & ~ref_q;
    hit       = (state_q == T_RUN) & ref_rise & ~osc_rise;
    timeout   = (state_q == T_RUN) & ~ref_rise & ~osc_rise & (cnt_q == CNT_MAX);
    res_vld_o = (osc_rise & ref_rise) | hit | timeout;
    res_o     = hit ? cnt_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q   <= 1'b0;
      ref_q   <= 1'b0;
      state_q <= T_IDLE;
      cnt_q   <= '0;
    end else begin
      osc_q <= osc_i;
      ref_q <= ref_i;
      if (osc_rise) begin
        state_q <= ref_rise ? T_IDLE : T_RUN;
        cnt_q   <= PHASE_W'(1);
      end else if (hit || timeout) begin
        state_q <= T_IDLE;
        cnt_q   <= '0;
      end else if (state_q == T_RUN) begin
        cnt_q <= cnt_q + PHASE_W'(1);
      end
    end
  end

  p_coincide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_rise && ref_rise) |-> (res_vld_o && res_o == '0));

  p_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == T_RUN && cnt_q == CNT_MAX && !osc_rise && !ref_rise)
    |=> (state_q == T_IDLE));

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_rise && !ref_rise) |=> (state_q == T_RUN && cnt_q == PHASE_W'(1)));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == T_IDLE && !osc_rise) |-> !res_vld_o);
endmodule

// File: rtl/pau_phase_acc.sv
module pau_phase_acc #(
  parameter int PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               res_vld_i,
  input  logic [PHASE_W-1:0] res_i,
  input  logic               update_i,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] load_phase_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q, corr_q;
  logic               apply;

  assign apply   = update_i & ~load_i;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q <= '0;
    end else if (res_vld_i) begin
      corr_q <= res_i;
    end else if (apply) begin
      corr_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (load_i) begin
      phase_q <= load_phase_i;
    end else if (update_i) begin
      phase_q <= phase_q + corr_q; // wraps modulo 2^PHASE_W
    end
  end

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !load_i) |=> (phase_q == PHASE_W'($past(phase_q) + $past(corr_q))));

  p_consume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !load_i && !res_vld_i) |=> (corr_q == '0));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (phase_q == $past(load_phase_i)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !update_i) |=> $stable(phase_q));
endmodule

// File: rtl/phase_align_unit.sv
module phase_align_unit #(
  parameter int SUM_W   = 10,
  parameter int PHASE_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic                    osc_i,
  input  logic                    update_i,
  input  logic                    load_i,
  input  logic [PHASE_W-1:0]      load_phase_i,
  output logic [PHASE_W-1:0]      phase_o
);
  logic               ref_lvl;
  logic               res_vld;
  logic [PHASE_W-1:0] res;

  pau_ref_gen #(.SUM_W(SUM_W)) u_ref (
    .sum_i (sum_i),
    .osc_i (osc_i),
    .ref_o (ref_lvl)
  );

  pau_edge_timer #(.PHASE_W(PHASE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_i     (osc_i),
    .ref_i     (ref_lvl),
    .res_vld_o (res_vld),
    .res_o     (res)
  );

  pau_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .res_vld_i    (res_vld),
    .res_i        (res),
    .update_i     (update_i),
    .load_i       (load_i),
    .load_phase_i (load_phase_i),
    .phase_o      (phase_o)
  );

  p_zero_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_i == '0) |-> (ref_lvl == osc_i));
endmodule

// File: tb/phase_align_unit_bench.sv
`timescale 1ns/1ps
module phase_align_unit_bench;
  localparam int SUM_W   = 10;
  localparam int PHASE_W = 4;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic signed [SUM_W-1:0] sum_i = -10'sd5;
  logic                    osc_i = 1'b0;
  logic                    update_i = 1'b0;
  logic                    load_i = 1'b0;
  logic [PHASE_W-1:0]      load_phase_i = '0;
  logic [PHASE_W-1:0]      phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [PHASE_W-1:0] exp;
    string              tag;
  } item_t;
  item_t q[$];

  always #2.5 clk_i = ~clk_i;

  phase_align_unit #(.SUM_W(SUM_W), .PHASE_W(PHASE_W)) u_phase_align_unit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sum_i        (sum_i),
    .osc_i        (osc_i),
    .update_i     (update_i),
    .load_i       (load_i),
    .load_phase_i (load_phase_i),
    .phase_o      (phase_o)
  );

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (phase_o !== it.exp) begin
          failures++;
          $display("FAIL %s: phase_o=%0d expected=%0d", it.tag, phase_o, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    osc_i = 1'b0; sum_i = -10'sd5; update_i = 1'b0; load_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // expect phase after the coming edge with present inputs
  task automatic edge_expect(input logic [PHASE_W-1:0] e, input string tag);
    item_t it;
    @(posedge clk_i);
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  // oscillator rises at t=0, reference rises at t=d
  task automatic measure(input int d);
    idle(2);
    for (int t = 0; t < 20; t++) begin
      osc_i = (t < 8);
      sum_i = (t >= d && t < d + 4) ? 10'sd5 : -10'sd5;
      @(negedge clk_i);
    end
    idle(2);
  endtask

  task automatic measure_zero();
    idle(2);
    for (int t = 0; t < 20; t++) begin
      osc_i = (t < 8);
      sum_i = '0;
      @(negedge clk_i);
    end
    idle(2);
  endtask

  task automatic do_update(input logic [PHASE_W-1:0] e, input string tag);
    update_i = 1'b1;
    edge_expect(e, tag);
    update_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (phase_o !== '0) begin
      failures++;
      $display("FAIL R8 reset: phase_o=%0d expected=0", phase_o);
    end
    rst_ni = 1'b1;
    idle(1);
    do_update(4'd0, "R8 no pending correction after reset");

    measure(3);
    do_update(4'd3, "R1 R3 offset 3");
    do_update(4'd3, "R6 correction consumed");

    measure(0);
    do_update(4'd3, "R3 coincident edges give 0");

    measure(15);
    do_update(4'd2, "R3 R5 offset 15 wraps 3+15");

    measure(16);
    do_update(4'd2, "R4 timeout gives 0");

    measure(9);
    edge_expect(4'd2, "R9 hold without update");
    do_update(4'd11, "R1 offset 9 reference low then high");

    measure(6);
    measure_zero();
    do_update(4'd11, "R2 zero sum replaces pending with 0");

    measure(7);
    load_i = 1'b1; update_i = 1'b1; load_phase_i = 4'd12;
    edge_expect(4'd12, "R7 load overrides update");
    load_i = 1'b0; update_i = 1'b0;
    do_update(4'd3, "R5 R7 pending kept, 12+7 wraps");

    // restart: second oscillator rise at t=3, reference rise at t=8
    idle(2);
    for (int t = 0; t < 14; t++) begin
      osc_i = (t == 0) || (t >= 3 && t < 11);
      sum_i = (t >= 8 && t < 12) ? 10'sd5 : -10'sd5;
      @(negedge clk_i);
    end
    idle(2);
    do_update(4'd8, "R10 timer restarted by new oscillator edge");

    load_i = 1'b1; load_phase_i = 4'd5;
    edge_expect(4'd5, "R7 plain load");
    load_i = 1'b0;

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule